// File: doc/BRIEF.md
# USB Device Address and Reset Controller

This block sits at device level in a USB function controller. Software writes the host-assigned 7-bit function address through a small register port. The new value is held pending until the control transfer in progress signals its end. Only then does it become the address used to match incoming tokens. A readable pending flag tells software whether the last written value has taken effect.

The block also reacts to bus events. A detected bus reset forces the address to zero, clears the endpoint index and the pending state, pulses strobes that flush the endpoint FIFOs and clear the endpoint control/status registers, restores the interrupt enables except the suspend enable, and raises the reset interrupt. Software can force a full reset of the block through the power register. With suspend detection enabled, suspend signalling puts the block in a suspended state, and resume signalling or a bus reset takes it out again. Each of these events can raise an interrupt flag. The flags are cleared when software reads them.

Register map on `reg_sel`: 0 = address, 1 = power, 2 = interrupt flags, 3 = interrupt enables, 4 = endpoint index. Read data is registered and appears on `reg_rdata` the cycle after the `reg_rd` strobe.

Top module: `usbf_dev_ctrl`

## Requirements
- R1: After `rst`, the address register reads 0x00, the power register reads 0x00, the flags read 0x00, the enables read 0x05, the index reads 0x00, `eff_addr` is 0 and `irq` is 0.
- R2: A write to the address register reads back as {1, written bits 6:0}. Bit 7 of the write data is ignored, and bit 7 of the read value is the update-pending flag.
- R3: `eff_addr` keeps its previous value while an address is pending. It takes the pending value one cycle after an `xfer_done` pulse. A second write before that pulse replaces the pending value.
- R4: The pending flag reads 0 from the same edge at which `eff_addr` updates. An `xfer_done` pulse with nothing pending changes nothing.
- R5: On `bus_rst_det`, `eff_addr`, the pending address and the index register become 0. `fifo_flush` and `csr_clear` are high for exactly the next cycle. Power register bit 3 is set.
- R6: Power register bit 3 is cleared by a read of the power register.
- R7: On `bus_rst_det`, enable bits 0 (reset) and 2 (resume) are set and enable bit 1 (suspend) keeps its value. The flags become 0x01 (reset flag only).
- R8: Writing 1 to power register bit 3 returns every register and output to its R1 value one cycle after the write edge.
- R9: With power bit 0 (suspend detection enable) set, a `suspend_det` pulse sets power bit 1 (suspended), and sets flag bit 1 if enable bit 1 is set. With power bit 0 clear, the pulse has no effect.
- R10: While suspended, a `resume_det` pulse clears power bit 1 and sets flag bit 2 if enable bit 2 is set. A bus reset also clears power bit 1.
- R11: A read of the flags register returns the flags and clears them. `irq` is high exactly while any flag is set.
- R12: `addr_match` is high one cycle after `tok_addr` equals `eff_addr`. It never matches the pending address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| xfer_done | input | 1 | End-of-transfer pulse |
| bus_rst_det | input | 1 | Bus reset detected pulse |
| suspend_det | input | 1 | Suspend signalling detected pulse |
| resume_det | input | 1 | Resume signalling detected pulse |
| tok_addr | input | 7 | Address field of the incoming token |
| addr_match | output | 1 | Token address equals the effective address |
| eff_addr | output | 7 | Effective function address |
| fifo_flush | output | 1 | One-cycle endpoint FIFO flush strobe |
| csr_clear | output | 1 | One-cycle endpoint CSR clear strobe |
| irq | output | 1 | OR of the interrupt flags |

## Verification
Every result is due one clock after the edge that samples its stimulus. This covers `eff_addr` after `xfer_done`, the strobes and flags after a bus reset, `addr_match` after `tok_addr`, and `reg_rdata` after `reg_rd`. The software reset takes one extra cycle, because it first registers its own request. The bench drives on falling edges and samples on the falling edge after the edge that acts on the stimulus. For the software reset it waits one further falling edge, and it checks the strobes on the following cycle to confirm that they last a single cycle. The address path is swept over all 128 values, each checked before and after its `xfer_done`.

// File: rtl/usbf_ctl_pkg.sv
package usbf_ctl_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PWR  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_FLAG = 3'd2;
  localparam logic [SEL_W-1:0] SEL_IEN  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_IDX  = 3'd4;

  localparam int NIRQ     = 3;
  localparam int IRQ_RST  = 0;
  localparam int IRQ_SUSP = 1;
  localparam int IRQ_RES  = 2;
  localparam logic [NIRQ-1:0] IEN_DEFAULT = 3'b101;

  localparam int PWR_SUSEN = 0;
  localparam int PWR_SUSP  = 1;
  localparam int PWR_RST   = 3;
endpackage

// File: rtl/usbf_addr_unit.sv
module usbf_addr_unit #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              xfer_done,
  input  logic              bus_rst,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              upd
);
  always_ff @(posedge clk) begin
    if (rst_all || bus_rst) begin
      eff_addr  <= '0;
      pend_addr <= '0;
      upd       <= 1'b0;
    end else begin
      if (xfer_done && upd) eff_addr <= pend_addr;
      if (wr_en) begin
        pend_addr <= wr_addr;
        upd       <= 1'b1;
      end else if (xfer_done && upd) begin
        upd <= 1'b0;
      end
    end
  end

  assert_wr_sets_pending_R2: assert property (@(posedge clk) disable iff (rst_all)
    (wr_en && !bus_rst) |=> upd);

  assert_eff_held_R3: assert property (@(posedge clk) disable iff (rst_all)
    !$stable(eff_addr) |-> ($past(xfer_done && upd) || $past(bus_rst) || $past(rst_all)));

  assert_pending_clear_R4: assert property (@(posedge clk) disable iff (rst_all)
    $fell(upd) |-> ($past(xfer_done) || $past(bus_rst) || $past(rst_all)));
endmodule

// File: rtl/usbf_power_unit.sv
module usbf_power_unit
  import usbf_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rst_all,
  input  logic pwr_wr,
  input  logic wr_susen,
  input  logic wr_rst,
  input  logic pwr_rd,
  input  logic bus_rst,
  input  logic suspend_det,
  input  logic resume_det,
  output logic soft_q,
  output logic susp_en,
  output logic suspended,
  output logic rst_stat,
  output logic fifo_flush,
  output logic csr_clear,
  output logic susp_evt,
  output logic res_evt
);
  assign susp_evt = suspend_det && susp_en && !suspended && !bus_rst;
  assign res_evt  = resume_det && suspended && !bus_rst;

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= pwr_wr && wr_rst;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      susp_en    <= 1'b0;
      suspended  <= 1'b0;
      rst_stat   <= 1'b0;
      fifo_flush <= 1'b0;
      csr_clear  <= 1'b0;
    end else begin
      fifo_flush <= bus_rst;
      csr_clear  <= bus_rst;
      if (pwr_wr) susp_en <= wr_susen;
      if (bus_rst) begin
        suspended <= 1'b0;
        rst_stat  <= 1'b1;
      end else begin
        if (susp_evt)     suspended <= 1'b1;
        else if (res_evt) suspended <= 1'b0;
        if (pwr_rd) rst_stat <= 1'b0;
      end
    end
  end

  assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (rst_all)
    (suspend_det && susp_en && !bus_rst && !resume_det) |=> suspended);

  assert_reset_leaves_suspend_R10: assert property (@(posedge clk) disable iff (rst_all)
    bus_rst |=> (!suspended && rst_stat));
endmodule

// File: rtl/usbf_irq_unit.sv
module usbf_irq_unit
  import usbf_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_all,
  input  logic            ien_wr,
  input  logic [NIRQ-1:0] ien_wdata,
  input  logic            flag_rd,
  input  logic            bus_rst,
  input  logic            susp_evt,
  input  logic            res_evt,
  output logic [NIRQ-1:0] ien,
  output logic [NIRQ-1:0] flags
);
  logic [NIRQ-1:0] evt;

  always_comb begin
    evt           = '0;
    evt[IRQ_SUSP] = susp_evt;
    evt[IRQ_RES]  = res_evt;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      ien   <= IEN_DEFAULT;
      flags <= '0;
    end else if (bus_rst) begin
      ien          <= ien | IEN_DEFAULT;
      flags        <= '0;
      flags[IRQ_RST] <= 1'b1;
    end else begin
      if (ien_wr) ien <= ien_wdata;
      flags <= (flag_rd ? '0 : flags) | (evt & ien);
    end
  end

  assert_bus_reset_irq_R7: assert property (@(posedge clk) disable iff (rst_all)
    bus_rst |=> (flags == 3'b001 && ien[IRQ_RST] && ien[IRQ_RES]));

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst_all)
    (flag_rd && !bus_rst && !susp_evt && !res_evt) |=> (flags == '0));
endmodule

// File: rtl/usbf_dev_ctrl.sv
module usbf_dev_ctrl
  import usbf_ctl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [ADDR_W:0]   reg_wdata,
  output logic [ADDR_W:0]   reg_rdata,
  input  logic              xfer_done,
  input  logic              bus_rst_det,
  input  logic              suspend_det,
  input  logic              resume_det,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              addr_match,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              fifo_flush,
  output logic              csr_clear,
  output logic              irq
);
  localparam int DATA_W = ADDR_W + 1;

  logic              soft_q, rst_all;
  logic              wr_addr_hit, wr_pwr_hit, wr_ien_hit, wr_idx_hit;
  logic              rd_pwr_hit, rd_flag_hit;
  logic [ADDR_W-1:0] pend_addr;
  logic              upd;
  logic              susp_en, suspended, rst_stat, susp_evt, res_evt;
  logic [NIRQ-1:0]   ien, flags;
  logic [IDX_W-1:0]  ep_idx;
  logic [DATA_W-1:0] pwr_view, rd_mux;
  logic              unused_wdata;

  assign rst_all      = rst || soft_q;
  assign unused_wdata = reg_wdata[DATA_W-1];

  assign wr_addr_hit = reg_wr && (reg_sel == SEL_ADDR);
  assign wr_pwr_hit  = reg_wr && (reg_sel == SEL_PWR);
  assign wr_ien_hit  = reg_wr && (reg_sel == SEL_IEN);
  assign wr_idx_hit  = reg_wr && (reg_sel == SEL_IDX);
  assign rd_pwr_hit  = reg_rd && (reg_sel == SEL_PWR);
  assign rd_flag_hit = reg_rd && (reg_sel == SEL_FLAG);

  usbf_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_all   (rst_all),
    .wr_en     (wr_addr_hit),
    .wr_addr   (reg_wdata[ADDR_W-1:0]),
    .xfer_done (xfer_done),
    .bus_rst   (bus_rst_det),
    .eff_addr  (eff_addr),
    .pend_addr (pend_addr),
    .upd       (upd)
  );

  usbf_power_unit u_pwr (
    .clk         (clk),
    .rst         (rst),
    .rst_all     (rst_all),
    .pwr_wr      (wr_pwr_hit),
    .wr_susen    (reg_wdata[PWR_SUSEN]),
    .wr_rst      (reg_wdata[PWR_RST]),
    .pwr_rd      (rd_pwr_hit),
    .bus_rst     (bus_rst_det),
    .suspend_det (suspend_det),
    .resume_det  (resume_det),
    .soft_q      (soft_q),
    .susp_en     (susp_en),
    .suspended   (suspended),
    .rst_stat    (rst_stat),
    .fifo_flush  (fifo_flush),
    .csr_clear   (csr_clear),
    .susp_evt    (susp_evt),
    .res_evt     (res_evt)
  );

  usbf_irq_unit u_irq (
    .clk       (clk),
    .rst_all   (rst_all),
    .ien_wr    (wr_ien_hit),
    .ien_wdata (reg_wdata[NIRQ-1:0]),
    .flag_rd   (rd_flag_hit),
    .bus_rst   (bus_rst_det),
    .susp_evt  (susp_evt),
    .res_evt   (res_evt),
    .ien       (ien),
    .flags     (flags)
  );

  assign irq = |flags;

  always_ff @(posedge clk) begin
    if (rst_all || bus_rst_det) ep_idx <= '0;
    else if (wr_idx_hit)        ep_idx <= reg_wdata[IDX_W-1:0];
  end

  always_comb begin
    pwr_view            = '0;
    pwr_view[PWR_SUSEN] = susp_en;
    pwr_view[PWR_SUSP]  = suspended;
    pwr_view[PWR_RST]   = rst_stat;
    case (reg_sel)
      SEL_ADDR: rd_mux = {upd, pend_addr};
      SEL_PWR:  rd_mux = pwr_view;
      SEL_FLAG: rd_mux = DATA_W'(flags);
      SEL_IEN:  rd_mux = DATA_W'(ien);
      SEL_IDX:  rd_mux = DATA_W'(ep_idx);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      reg_rdata  <= '0;
      addr_match <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      addr_match <= (tok_addr == eff_addr);
    end
  end

  assert_bus_reset_strobes_R5: assert property (@(posedge clk) disable iff (rst_all)
    bus_rst_det |=> (fifo_flush && csr_clear && eff_addr == '0));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst_all)
    (fifo_flush && !bus_rst_det) |=> !fifo_flush);
endmodule

// File: tb/test_usbf_dev_ctrl.sv
module test_usbf_dev_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xfer_done = 1'b0, bus_rst_det = 1'b0, suspend_det = 1'b0, resume_det = 1'b0;
  logic [6:0] tok_addr = '0;
  logic       addr_match, fifo_flush, csr_clear, irq;
  logic [6:0] eff_addr;

  int tests = 0;
  int fails = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  usbf_dev_ctrl i_usbf_dev_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .bus_rst_det(bus_rst_det), .suspend_det(suspend_det), .resume_det(resume_det),
    .tok_addr(tok_addr), .addr_match(addr_match), .eff_addr(eff_addr),
    .fifo_flush(fifo_flush), .csr_clear(csr_clear), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  // 0 xfer_done, 1 bus reset, 2 suspend, 3 resume
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: xfer_done = 1'b1;
      1: bus_rst_det = 1'b1;
      2: suspend_det = 1'b1;
      default: resume_det = 1'b1;
    endcase
    @(negedge clk);
    xfer_done = 1'b0; bus_rst_det = 1'b0; suspend_det = 1'b0; resume_det = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 eff_addr", eff_addr, 0);
    chk("R1 irq", irq, 0);
    rd(3'd0, rv); chk("R1 addr reg", rv, 8'h00);
    rd(3'd1, rv); chk("R1 power reg", rv, 8'h00);
    rd(3'd2, rv); chk("R1 flags", rv, 8'h00);
    rd(3'd3, rv); chk("R1 enables", rv, 8'h05);
    rd(3'd4, rv); chk("R1 index", rv, 8'h00);

    // R2/R3/R4/R12 sweep over every address
    prev = 7'd0;
    for (int a = 0; a < 128; a++) begin
      wr(3'd0, {a[0], 7'(a)});
      rd(3'd0, rv); chk("R2 pending readback", rv, {1'b1, 7'(a)});
      chk("R3 eff held before end", eff_addr, prev);
      @(negedge clk); tok_addr = 7'(a);
      @(negedge clk);
      chk("R12 no match on pending", addr_match, (7'(a) == prev));
      pulse(0);
      chk("R3 eff after end", eff_addr, a);
      rd(3'd0, rv); chk("R4 pending cleared", rv, {1'b0, 7'(a)});
      chk("R12 match effective", addr_match, 1);
      @(negedge clk); tok_addr = 7'(a) ^ 7'h01;
      @(negedge clk); chk("R12 mismatch", addr_match, 0);
      prev = 7'(a);
    end

    // R3 second write replaces pending
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    chk("R3 eff held after two writes", eff_addr, 7'h7F);
    pulse(0);
    chk("R3 second write wins", eff_addr, 7'h22);
    // R4 end of transfer with nothing pending
    pulse(0);
    chk("R4 idle end no change", eff_addr, 7'h22);
    rd(3'd0, rv); chk("R4 idle flag", rv, 8'h22);

    // R5/R6/R7 bus reset
    wr(3'd3, 8'h02);
    wr(3'd4, 8'h09);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h33);
    pulse(1);
    chk("R5 flush strobe", fifo_flush, 1);
    chk("R5 csr strobe", csr_clear, 1);
    chk("R5 eff zero", eff_addr, 0);
    chk("R11 irq after reset", irq, 1);
    @(negedge clk);
    chk("R5 flush one cycle", fifo_flush, 0);
    chk("R5 csr one cycle", csr_clear, 0);
    rd(3'd0, rv); chk("R5 addr reg zero", rv, 8'h00);
    rd(3'd4, rv); chk("R5 index zero", rv, 8'h00);
    rd(3'd3, rv); chk("R7 enables", rv, 8'h07);
    rd(3'd2, rv); chk("R7 flags", rv, 8'h01);
    chk("R11 irq cleared", irq, 0);
    rd(3'd2, rv); chk("R11 flags cleared", rv, 8'h00);
    rd(3'd1, rv); chk("R5 power bit3", rv, 8'h09);
    rd(3'd1, rv); chk("R6 bit3 read clear", rv, 8'h01);

    // R9/R10 suspend and resume
    pulse(2);
    rd(3'd1, rv); chk("R9 suspended", rv, 8'h03);
    rd(3'd2, rv); chk("R9 suspend flag", rv, 8'h02);
    pulse(3);
    rd(3'd1, rv); chk("R10 resumed", rv, 8'h01);
    rd(3'd2, rv); chk("R10 resume flag", rv, 8'h04);
    wr(3'd1, 8'h00);
    pulse(2);
    rd(3'd1, rv); chk("R9 detect disabled", rv, 8'h00);
    rd(3'd2, rv); chk("R9 no flag disabled", rv, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h05);
    pulse(2);
    rd(3'd1, rv); chk("R9 suspended masked", rv, 8'h03);
    rd(3'd2, rv); chk("R9 masked flag", rv, 8'h00);
    pulse(1);
    rd(3'd1, rv); chk("R10 bus reset leaves suspend", rv, 8'h09);
    rd(3'd2, rv); chk("R7 flags again", rv, 8'h01);

    // R8 software reset
    wr(3'd0, 8'h44);
    pulse(0);
    chk("R3 eff before soft reset", eff_addr, 7'h44);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h03);
    pulse(2);
    wr(3'd1, 8'h09);
    @(negedge clk);
    chk("R8 eff default", eff_addr, 0);
    chk("R8 irq default", irq, 0);
    rd(3'd0, rv); chk("R8 addr default", rv, 8'h00);
    rd(3'd1, rv); chk("R8 power default", rv, 8'h00);
    rd(3'd3, rv); chk("R8 enables default", rv, 8'h05);
    rd(3'd4, rv); chk("R8 index default", rv, 8'h00);
    rd(3'd2, rv); chk("R8 flags default", rv, 8'h00);

    finish_run();
  end
endmodule